// File: doc/BRIEF.md
# Configurable Logic Output Cell

This block is one output cell of a sum-of-products programmable logic device. It takes a bundle of product terms from the AND array and turns them into a pin value, a tristate enable and a feedback signal for the array. Two device-wide mode bits and two per-cell bits choose what the cell does. It can be a registered output, a combinational output, a combinational I/O whose enable comes from a product term, or a dedicated input that takes its feedback from the neighbouring pin.

A device holds a row of these cells. All cells share the clock, the active-low output-enable pin and the two mode bits. The two cells at the ends of the row are built with `END_CELL=1`, which steers their feedback selector from the other mode bit. Cells that must give no feedback in dedicated-output mode are built with `NO_FB_DED_OUT=1`. The output register has a synchronous active-low reset and a preload path for test.

Top module: `logic_out_cell`

## Requirements
- R1: The register loads (OR of all NUM_TERMS terms) XOR `loc_inv` on each rising clock edge when `rst_n`=1 and `preload_en`=0, in every mode. Registered mode is `glb_mode0`=0, `glb_mode1`=1, `loc_sel`=0, and in it `out_val` equals the register.
- R2: In registered mode `out_en` equals the inverse of `glb_oe_n`.
- R3: In registered mode `fb` equals the register contents, not a pin.
- R4: With `glb_mode0`=1, `glb_mode1`=0, `loc_sel`=0 (dedicated output), `out_val` is (OR of all terms) XOR `loc_inv` in the same cycle, and `out_en` is 1.
- R5: In dedicated-output mode `fb` equals `adj_pin_in`, or is 0 when the cell is built with `NO_FB_DED_OUT`=1.
- R6: With `glb_mode0`=1, `glb_mode1`=0, `loc_sel`=1 (dedicated input), `out_en` is 0, `out_val` is 0 and `fb` equals `adj_pin_in`.
- R7: With `glb_mode1`=1 and `loc_sel`=1 (combinational I/O, either value of `glb_mode0`), `out_val` is (OR of terms 0 to NUM_TERMS-2) XOR `loc_inv`, `out_en` equals term NUM_TERMS-1, and `fb` equals `pin_in` in a cell built with `END_CELL`=0.
- R8: In a cell built with `END_CELL`=1, combinational I/O with `glb_mode0`=1 feeds back `adj_pin_in`, while with `glb_mode0`=0 it feeds back `pin_in`.
- R9: `rst_n`=0 at a rising edge clears the register, overriding preload and D.
- R10: `preload_en`=1 with `rst_n`=1 loads `preload_d` at the next rising edge instead of the D value.
- R11: The unlisted settings (`glb_mode0`=0 with `glb_mode1`=0, and `glb_mode0`=1, `glb_mode1`=1, `loc_sel`=0) behave as dedicated input: `out_en`=0, `out_val`=0, `fb`=`adj_pin_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock; register loads on the rising edge |
| rst_n | input | 1 | Synchronous active-low register clear |
| glb_mode0 | input | 1 | Global mode bit 0 (0 allows registers) |
| glb_mode1 | input | 1 | Global mode bit 1 (register-family emulation) |
| loc_sel | input | 1 | Per-cell configuration select |
| loc_inv | input | 1 | Per-cell output polarity, 1 inverts |
| terms | input | NUM_TERMS | Product terms from the AND array |
| glb_oe_n | input | 1 | Global active-low output enable for registered mode |
| pin_in | input | 1 | Value seen on this cell's own pin |
| adj_pin_in | input | 1 | Value seen on the neighbouring cell's pin |
| preload_en | input | 1 | Test strobe: load `preload_d` at the next edge |
| preload_d | input | 1 | Test preload value |
| out_val | output | 1 | Value driven towards the pin |
| out_en | output | 1 | Tristate enable for the pin |
| fb | output | 1 | Feedback into the AND array |

## Verification
The bench goes after the feedback selector, where an end cell given the ordinary mode bit would feed back its own pin in non-registered I/O mode, and where an unlisted setting could leak register or pin values instead of the neighbour. It checks that the output-enable term is removed from the sum in I/O mode, since a design that kept it would drive 1 whenever the pin is enabled. It checks that preload beats D and that reset beats preload, where a wrong priority leaves the register holding the D value. The polarity checks catch an XOR misplaced after the register or a missing inversion in the combinational path.

// File: rtl/lgc_cell_pkg.sv
// Package: shared types of the configurable logic output cell.
// Assumes: nothing beyond IEEE 1800-2017.
package lgc_cell_pkg;

    // Operating mode decoded from the configuration bits.
    typedef enum logic [1:0] {
        CM_REG      = 2'd0,
        CM_COMB_OUT = 2'd1,
        CM_COMB_IO  = 2'd2,
        CM_DED_IN   = 2'd3
    } cell_mode_t;

    // Source of the feedback into the product-term array.
    typedef enum logic [1:0] {
        FB_ZERO = 2'd0,
        FB_Q    = 2'd1,
        FB_PIN  = 2'd2,
        FB_ADJ  = 2'd3
    } fb_src_t;

endpackage

// File: rtl/cell_mode_decode.sv
// Module: cell_mode_decode
// Turns the two global and the select bit into a cell mode and a feedback
// source. End cells steer the feedback selector from the inverse of mode bit 0
// rather than from mode bit 1. Unlisted settings fall back to dedicated input.
// Assumes: configuration bits are static during normal operation.
module cell_mode_decode
    import lgc_cell_pkg::*;
#(
    parameter bit END_CELL      = 1'b0,
    parameter bit NO_FB_DED_OUT = 1'b0
) (
    input  logic       g0,
    input  logic       g1,
    input  logic       sel,
    output cell_mode_t mode,
    output fb_src_t    fb_src
);

    logic fb_steer;

    // Choose which global bit steers the feedback selector.
    generate
        if (END_CELL) begin : g_end_steer
            assign fb_steer = ~g0;
        end else begin : g_mid_steer
            assign fb_steer = g1;
        end
    endgenerate

    // Decode the mode table; anything unlisted maps to dedicated input.
    always_comb begin
        unique case ({g0, g1, sel})
            3'b010:         mode = CM_REG;
            3'b100:         mode = CM_COMB_OUT;
            3'b101:         mode = CM_DED_IN;
            3'b111, 3'b011: mode = CM_COMB_IO;
            default:        mode = CM_DED_IN;
        endcase
    end

    // Feedback selector with the mode-driven overrides applied last.
    always_comb begin
        if (!fb_steer) begin
            fb_src = FB_ADJ;
        end else if (sel) begin
            fb_src = FB_PIN;
        end else begin
            fb_src = FB_Q;
        end
        if (mode == CM_DED_IN) begin
            fb_src = FB_ADJ;
        end
        if (mode == CM_COMB_OUT && NO_FB_DED_OUT) begin
            fb_src = FB_ZERO;
        end
    end

endmodule

// File: rtl/cell_term_sum.sv
// Module: cell_term_sum
// ORs the product terms. When the top term is claimed as an output enable it
// is left out of the sum and passed on separately.
// Assumes: NUM_TERMS is at least 2.
module cell_term_sum #(
    parameter int NUM_TERMS = 8
) (
    input  logic [NUM_TERMS-1:0] terms,
    input  logic                 use_oe_term,
    output logic                 full_sum,
    output logic                 sum,
    output logic                 oe_term
);

    localparam int OE_IDX = NUM_TERMS - 1;

    logic [NUM_TERMS-1:0] chain;

    // Running OR over the terms, one stage per term.
    genvar i;
    generate
        for (i = 0; i < NUM_TERMS; i++) begin : g_or
            if (i == 0) begin : g_first
                assign chain[i] = terms[i];
            end else begin : g_next
                assign chain[i] = chain[i-1] | terms[i];
            end
        end
    endgenerate

    // Pick the full sum or the sum without the enable term.
    always_comb begin
        full_sum = chain[OE_IDX];
        sum      = use_oe_term ? chain[OE_IDX-1] : chain[OE_IDX];
        oe_term  = terms[OE_IDX];
    end

endmodule

// File: rtl/cell_flop.sv
// Module: cell_flop
// Output register with synchronous active-low clear and a test preload that
// takes priority over the D input.
// Assumes: a single clock domain.
module cell_flop (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    input  logic preload_en,
    input  logic preload_d,
    output logic q
);

    // Register update: clear, then preload, then data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (preload_en) begin
            q <= preload_d;
        end else begin
            q <= d;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> q == 1'b0); // R9
    AST_PRELOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        preload_en |=> q == $past(preload_d)); // R10
    AST_DATA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !preload_en |=> q == $past(d)); // R1

endmodule

// File: rtl/logic_out_cell.sv
// Module: logic_out_cell
// One output cell of a sum-of-products logic device: decodes its mode, sums
// the product terms, applies polarity ahead of the register and drives the
// pin value, tristate enable and array feedback.
// Assumes: inputs change away from the rising clock edge; configuration is
// static while the cell is in use.
module logic_out_cell
    import lgc_cell_pkg::*;
#(
    parameter int NUM_TERMS     = 8,
    parameter bit END_CELL      = 1'b0,
    parameter bit NO_FB_DED_OUT = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 glb_mode0,
    input  logic                 glb_mode1,
    input  logic                 loc_sel,
    input  logic                 loc_inv,
    input  logic [NUM_TERMS-1:0] terms,
    input  logic                 glb_oe_n,
    input  logic                 pin_in,
    input  logic                 adj_pin_in,
    input  logic                 preload_en,
    input  logic                 preload_d,
    output logic                 out_val,
    output logic                 out_en,
    output logic                 fb
);

    localparam int OE_IDX = NUM_TERMS - 1;

    cell_mode_t mode;
    fb_src_t    fb_src;
    logic       full_sum;
    logic       sum;
    logic       oe_term;
    logic       reg_d;
    logic       reg_q;

    cell_mode_decode #(
        .END_CELL      (END_CELL),
        .NO_FB_DED_OUT (NO_FB_DED_OUT)
    ) u_decode (
        .g0     (glb_mode0),
        .g1     (glb_mode1),
        .sel    (loc_sel),
        .mode   (mode),
        .fb_src (fb_src)
    );

    cell_term_sum #(
        .NUM_TERMS (NUM_TERMS)
    ) u_sum (
        .terms       (terms),
        .use_oe_term (mode == CM_COMB_IO),
        .full_sum    (full_sum),
        .sum         (sum),
        .oe_term     (oe_term)
    );

    // Polarity sits ahead of the register input.
    assign reg_d = full_sum ^ loc_inv;

    cell_flop u_flop (
        .clk        (clk),
        .rst_n      (rst_n),
        .d          (reg_d),
        .preload_en (preload_en),
        .preload_d  (preload_d),
        .q          (reg_q)
    );

    // Pin value and tristate enable per mode.
    always_comb begin
        unique case (mode)
            CM_REG: begin
                out_val = reg_q;
                out_en  = ~glb_oe_n;
            end
            CM_COMB_OUT: begin
                out_val = sum ^ loc_inv;
                out_en  = 1'b1;
            end
            CM_COMB_IO: begin
                out_val = sum ^ loc_inv;
                out_en  = oe_term;
            end
            default: begin
                out_val = 1'b0;
                out_en  = 1'b0;
            end
        endcase
    end

    // Feedback multiplexer into the array.
    always_comb begin
        unique case (fb_src)
            FB_Q:    fb = reg_q;
            FB_PIN:  fb = pin_in;
            FB_ADJ:  fb = adj_pin_in;
            default: fb = 1'b0;
        endcase
    end

    AST_REG_OE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_mode0 && glb_mode1 && !loc_sel) |-> out_en == !glb_oe_n); // R2
    AST_DED_OUT_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_mode0 && !glb_mode1 && !loc_sel) |-> out_en); // R4
    AST_DED_IN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_mode0 && !glb_mode1 && loc_sel) |-> (!out_en && fb == adj_pin_in)); // R6
    AST_IO_OE_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_mode1 && loc_sel) |-> out_en == terms[OE_IDX]); // R7
    AST_UNLISTED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ((!glb_mode0 && !glb_mode1) || (glb_mode0 && glb_mode1 && !loc_sel))
        |-> (!out_en && !out_val)); // R11

endmodule

// File: tb/logic_out_cell_bench.sv
// Scoreboard bench: the driver pushes expected items, the monitor pops them
// and compares against the three cell variants.
module logic_out_cell_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NT = 8;

    typedef struct {
        int    dut;
        string req;
        logic  ov;
        logic  oe;
        logic  fbv;
    } exp_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          g0 = 1'b0, g1 = 1'b1, sel = 1'b0, inv = 1'b0;
    logic [NT-1:0] terms = '0;
    logic          oe_n = 1'b0, pin = 1'b0, adj = 1'b0, pl_en = 1'b0, pl_d = 1'b0;
    logic          ov0, oe0, fb0, ov1, oe1, fb1, ov2, oe2, fb2;
    logic          mq = 1'b0;
    int            total = 0;
    int            bad = 0;
    bit            done = 1'b0;
    exp_item_t     sb_q[$];
    event          chk_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    logic_out_cell #(.NUM_TERMS(NT), .END_CELL(1'b0), .NO_FB_DED_OUT(1'b0)) u_logic_out_cell (
        .clk(clk), .rst_n(rst_n), .glb_mode0(g0), .glb_mode1(g1), .loc_sel(sel),
        .loc_inv(inv), .terms(terms), .glb_oe_n(oe_n), .pin_in(pin),
        .adj_pin_in(adj), .preload_en(pl_en), .preload_d(pl_d),
        .out_val(ov0), .out_en(oe0), .fb(fb0));

    logic_out_cell #(.NUM_TERMS(NT), .END_CELL(1'b1), .NO_FB_DED_OUT(1'b0)) u_logic_out_cell_end (
        .clk(clk), .rst_n(rst_n), .glb_mode0(g0), .glb_mode1(g1), .loc_sel(sel),
        .loc_inv(inv), .terms(terms), .glb_oe_n(oe_n), .pin_in(pin),
        .adj_pin_in(adj), .preload_en(pl_en), .preload_d(pl_d),
        .out_val(ov1), .out_en(oe1), .fb(fb1));

    logic_out_cell #(.NUM_TERMS(NT), .END_CELL(1'b0), .NO_FB_DED_OUT(1'b1)) u_logic_out_cell_nofb (
        .clk(clk), .rst_n(rst_n), .glb_mode0(g0), .glb_mode1(g1), .loc_sel(sel),
        .loc_inv(inv), .terms(terms), .glb_oe_n(oe_n), .pin_in(pin),
        .adj_pin_in(adj), .preload_en(pl_en), .preload_d(pl_d),
        .out_val(ov2), .out_en(oe2), .fb(fb2));

    // Reference register built from R1, R9, R10.
    always @(posedge clk) begin
        if (!rst_n)     mq <= 1'b0;
        else if (pl_en) mq <= pl_d;
        else            mq <= (|terms) ^ inv;
    end

    // Expected {out_val, out_en, fb} from the requirements.
    function automatic logic [2:0] expect_fn(input bit is_end, input bit nofb);
        if (!g0 && g1 && !sel)       return {mq, ~oe_n, mq};                          // R1 R2 R3
        else if (g0 && !g1 && !sel)  return {(|terms) ^ inv, 1'b1, nofb ? 1'b0 : adj}; // R4 R5
        else if (g1 && sel)          return {(|terms[NT-2:0]) ^ inv, terms[NT-1],
                                             (is_end && g0) ? adj : pin};              // R7 R8
        else                         return {1'b0, 1'b0, adj};                         // R6 R11
    endfunction

    // Driver side: queue an expected item for one variant.
    task automatic push(input int dut, input string req);
        logic [2:0] e;
        exp_item_t  it;
        e = expect_fn(dut == 1, dut == 2);
        it.dut = dut; it.req = req; it.ov = e[2]; it.oe = e[1]; it.fbv = e[0];
        sb_q.push_back(it);
    endtask

    task automatic push_all(input string req);
        push(0, req); push(1, req); push(2, req);
        ->chk_ev;
    endtask

    task automatic set_cfg(input logic a, input logic b, input logic s, input logic p);
        @(negedge clk);
        g0 = a; g1 = b; sel = s; inv = p;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Monitor: pop and compare each expected item.
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                exp_item_t it;
                logic [2:0] act;
                it = sb_q.pop_front();
                act = (it.dut == 0) ? {ov0, oe0, fb0} :
                      (it.dut == 1) ? {ov1, oe1, fb1} : {ov2, oe2, fb2};
                total++;
                if (act !== {it.ov, it.oe, it.fbv}) begin
                    bad++;
                    $display("FAIL %s dut%0d: got out/en/fb=%b expected %b",
                             it.req, it.dut, act, {it.ov, it.oe, it.fbv});
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R9: reset state in registered mode.
        set_cfg(1'b0, 1'b1, 1'b0, 1'b0);
        terms = 8'h04; tick(); tick();
        push_all("R9 reset clears");
        @(negedge clk); rst_n = 1'b1;
        // R1 R3: load OR of terms.
        tick(); push_all("R1 R3 load true");
        @(negedge clk); inv = 1'b1; tick(); push_all("R1 polarity inverted");
        @(negedge clk); terms = 8'h00; tick(); push_all("R1 zero terms inverted");
        @(negedge clk); inv = 1'b0; terms = 8'h80; tick(); push_all("R1 top term alone");
        // R2: global enable.
        @(negedge clk); oe_n = 1'b1; settle(); push_all("R2 oe pin off");
        @(negedge clk); oe_n = 1'b0; settle(); push_all("R2 oe pin on");
        // R10: preload beats D.
        @(negedge clk); pl_en = 1'b1; pl_d = 1'b0; tick(); push_all("R10 preload 0");
        @(negedge clk); terms = 8'h00; pl_d = 1'b1; tick(); push_all("R10 preload 1");
        @(negedge clk); pl_en = 1'b0; tick(); push_all("R1 data after preload");
        // R9: reset beats preload and D.
        @(negedge clk); terms = 8'hFF; pl_en = 1'b1; pl_d = 1'b1; rst_n = 1'b0;
        tick(); push_all("R9 reset priority");
        @(negedge clk); rst_n = 1'b1; pl_en = 1'b0;
        // R4 R5: dedicated output.
        set_cfg(1'b1, 1'b0, 1'b0, 1'b0);
        terms = 8'h80; adj = 1'b1; settle(); push_all("R4 R5 ded out");
        @(negedge clk); inv = 1'b1; adj = 1'b0; settle(); push_all("R4 R5 ded out inv");
        @(negedge clk); terms = 8'h00; adj = 1'b1; settle(); push_all("R4 ded out zero");
        // R6: dedicated input.
        set_cfg(1'b1, 1'b0, 1'b1, 1'b0);
        terms = 8'hFF; adj = 1'b1; pin = 1'b0; settle(); push_all("R6 ded in adj1");
        @(negedge clk); adj = 1'b0; pin = 1'b1; settle(); push_all("R6 ded in adj0");
        // R7 R8: combinational I/O, non-registered device.
        set_cfg(1'b1, 1'b1, 1'b1, 1'b0);
        terms = 8'h80; pin = 1'b1; adj = 1'b0; settle(); push_all("R7 R8 io oe term only");
        @(negedge clk); terms = 8'h01; pin = 1'b0; adj = 1'b1; settle(); push_all("R7 R8 io data no oe");
        @(negedge clk); inv = 1'b1; terms = 8'hC0; settle(); push_all("R7 io inv");
        // R7 R8: combinational I/O in a registered device.
        set_cfg(1'b0, 1'b1, 1'b1, 1'b0);
        terms = 8'h81; pin = 1'b1; adj = 1'b0; settle(); push_all("R7 R8 io reg device");
        // R11: unlisted settings.
        set_cfg(1'b0, 1'b0, 1'b0, 1'b0);
        terms = 8'hFF; pin = 1'b0; adj = 1'b1; settle(); push_all("R11 mode 000");
        set_cfg(1'b0, 1'b0, 1'b1, 1'b1);
        adj = 1'b0; pin = 1'b1; settle(); push_all("R11 mode 001");
        set_cfg(1'b1, 1'b1, 1'b0, 1'b0);
        adj = 1'b1; settle(); push_all("R11 mode 110");
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule